// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns an asynchronous serial line into 8-bit characters. A frame opens with a low start bit. Eight data bits follow, least significant bit first. Then comes a parity bit, unless parity is switched off, and finally one high stop bit. The line passes through a two-flop synchronizer. A free-running enable, `tick_i`, paces all sampling at 16 ticks per bit. The start bit is checked again at mid-bit, so a short glitch on the line is not taken for a frame.

When a character completes, the byte is placed on `data_o` and `ready_o` rises. Three status flags are updated in that same cycle: overrun, parity error and framing error. Reading the data with `rd_i` drops `ready_o` only. The error flags stay set across later characters and across reads. Only a pulse on `rst_sta_i` clears them. If a new error arrives in the same cycle as that pulse, the error wins.

Top module: `uart_rx_sticky`

## Requirements
- R1: The data bits of a frame appear on `data_o` in their received order, with the first data bit after the start bit at bit 0.
- R2: `ready_o` rises when a character completes and falls on an `rd_i` pulse. A completion in the same cycle as `rd_i` keeps it set.
- R3: `par_mode_i` selects the parity: 0 even, 1 odd, 2 always 0, 3 always 1. If the received parity bit differs from the expected value, `par_err_o` is set in the same cycle as `ready_o`.
- R4: Values 4 to 7 of `par_mode_i` mean no parity bit. The stop bit then follows D7 directly, and `par_err_o` is never set.
- R5: A stop bit sampled low sets `frm_err_o` in the same cycle as `ready_o`.
- R6: A character that completes while `ready_o` is still high, with no read in that cycle, sets `ovr_o`. `data_o` then holds the newest character.
- R7: The error flags hold across later characters and across `rd_i`. A `rst_sta_i` pulse clears all three.
- R8: An error event in the same cycle as `rst_sta_i` leaves its flag set.
- R9: A line found high again at the middle of the start bit returns the receiver to idle, and no character is produced.
- R10: After reset, `data_o`, `ready_o` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| par_mode_i | input | 3 | Parity selection (see R3, R4) |
| rd_i | input | 1 | Data-read strobe, one cycle |
| rst_sta_i | input | 1 | Clear-status strobe, one cycle |
| data_o | output | 8 | Last received character |
| ready_o | output | 1 | Character available |
| ovr_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity-error flag |
| frm_err_o | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume that `par_mode_i` stays constant for the length of a frame, and that `rd_i` and `rst_sta_i` are single-cycle strobes. The stimulus changes the parity mode only while the line is idle. It holds `tick_i` high, so each bit lasts exactly 16 clocks, and it puts at least 24 idle clocks between frames. The completion pulse is brought out to the checker. This lets every flag rise be tied to a completed character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    PAR_EVEN  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_SPACE = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_NONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  function automatic logic par_used(input logic [2:0] mode);
    return mode < 3'd4;
  endfunction

  function automatic logic par_expect(input logic [2:0] mode, input logic [7:0] d);
    case (mode)
      3'd0:    return ^d;
      3'd1:    return ~^d;
      3'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // idle line is high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic [2:0]    par_mode_i,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OSR / 2;

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;
  logic          pbit_q;
  logic          bit_end;

  assign bit_end = (cnt_q == CW'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_o <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (st_q)
          ST_IDLE: if (!rx_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
          ST_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              st_q  <= rx_i ? ST_IDLE : ST_DATA;  // glitch rejection
              cnt_q <= '0;
              idx_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (bit_end) begin
              sh_q  <= {rx_i, sh_q[DW-1:1]};
              cnt_q <= '0;
              if (idx_q == IW'(DW - 1)) st_q <= par_used(par_mode_i) ? ST_PAR : ST_STOP;
              else                      idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (bit_end) begin
              pbit_q <= rx_i;
              cnt_q  <= '0;
              st_q   <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (bit_end) begin
              done_o <= 1'b1;
              ferr_o <= !rx_i;
              perr_o <= par_used(par_mode_i) && (pbit_q != par_expect(par_mode_i, sh_q));
              cnt_q  <= '0;
              st_q   <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          ready_o,
  output logic          ovr_o,
  output logic          perr_o,
  output logic          ferr_o
);
  logic ovr_ev, perr_ev, ferr_ev;

  assign ovr_ev  = done_i && ready_o && !rd_i;
  assign perr_ev = done_i && perr_i;
  assign ferr_ev = done_i && ferr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      if (done_i) data_o <= byte_i;
      if (done_i)    ready_o <= 1'b1;
      else if (rd_i) ready_o <= 1'b0;
      // set beats clear
      ovr_o  <= ovr_ev  || (ovr_o  && !clr_i);
      perr_o <= perr_ev || (perr_o && !clr_i);
      ferr_o <= ferr_ev || (ferr_o && !clr_i);
    end
  end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic [2:0]    par_mode_i,
  input  logic          rd_i,
  input  logic          rst_sta_i,
  output logic [DW-1:0] data_o,
  output logic          ready_o,
  output logic          ovr_o,
  output logic          par_err_o,
  output logic          frm_err_o
);
  logic          rx_s;
  logic          char_done;
  logic [DW-1:0] char_byte;
  logic          char_perr, char_ferr;

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rx_s)
  );

  uart_rx_deser #(.DW(DW), .OSR(OSR)) u_deser (
    .clk_i, .rst_ni, .rx_i(rx_s), .tick_i, .par_mode_i,
    .done_o(char_done), .byte_o(char_byte), .perr_o(char_perr), .ferr_o(char_ferr)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk_i, .rst_ni, .done_i(char_done), .byte_i(char_byte),
    .perr_i(char_perr), .ferr_i(char_ferr), .rd_i, .clr_i(rst_sta_i),
    .data_o, .ready_o, .ovr_o, .perr_o(par_err_o), .ferr_o(frm_err_o)
  );
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_i,
  input logic rst_sta_i,
  input logic done_i,
  input logic ready_i,
  input logic ovr_i,
  input logic perr_i,
  input logic ferr_i
);
  a_r2_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_i);
  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !ready_i);
  a_r7_perr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_i && !rst_sta_i |=> perr_i);
  a_r7_ferr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_i && !rst_sta_i |=> ferr_i);
  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i && !rst_sta_i |=> ovr_i);
  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sta_i && !done_i |=> !perr_i && !ferr_i && !ovr_i);
  a_r3_perr_with_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_i) |-> $past(done_i));
  a_r5_ferr_with_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ferr_i) |-> $past(done_i));
  a_r6_ovr_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> $past(done_i) && $past(ready_i));
endmodule

bind uart_rx_sticky uart_rx_sticky_chk u_chk (
  .clk_i, .rst_ni, .rd_i, .rst_sta_i,
  .done_i(char_done), .ready_i(ready_o), .ovr_i(ovr_o),
  .perr_i(par_err_o), .ferr_i(frm_err_o)
);

// File: tb/tb_uart_rx_sticky.sv
module tb_uart_rx_sticky;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i = 1'b1;
  logic [2:0] par_mode_i = 3'd0;
  logic       rd_i = 1'b0;
  logic       rst_sta_i = 1'b0;
  logic [7:0] data_o;
  logic       ready_o, ovr_o, par_err_o, frm_err_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  uart_rx_sticky dut (.*);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(logic [2:0] m, logic [7:0] d);
    case (m)
      3'd0: return ^d;
      3'd1: return ~^d;
      3'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send_bit(logic v);
    rxd_i = v;
    repeat (16) @(negedge clk_i);
  endtask

  // bad_par flips the parity bit; stop_v is the stop level
  task automatic send_frame(logic [7:0] d, bit bad_par, logic stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (par_mode_i < 3'd4) send_bit(exp_par(par_mode_i, d) ^ bad_par);
    send_bit(stop_v);
    rxd_i = 1'b1;
    repeat (24) @(negedge clk_i);
  endtask

  task automatic pulse_rd();
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    rst_sta_i = 1'b1; @(negedge clk_i); rst_sta_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R10 data", data_o, 0);
    check("R10 ready", ready_o, 0);
    check("R10 flags", {ovr_o, par_err_o, frm_err_o}, 0);
  endtask

  task automatic t_basic();
    par_mode_i = 3'd0;
    send_frame(8'hA5, 0, 1);
    check("R1 data A5", data_o, 8'hA5);
    check("R2 ready set", ready_o, 1);
    check("R3 no perr", par_err_o, 0);
    pulse_rd();
    check("R2 ready cleared", ready_o, 0);
    send_frame(8'h01, 0, 1);
    check("R1 lsb first", data_o, 8'h01);
    pulse_rd();
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      par_mode_i = 3'(m);
      send_frame(8'h5B + 8'(m), 0, 1);
      check($sformatf("R3 mode %0d good", m), par_err_o, 0);
      check($sformatf("R1 mode %0d data", m), data_o, 8'h5B + m);
      pulse_rd();
      send_frame(8'hC3, 1, 1);
      check($sformatf("R3 mode %0d bad", m), par_err_o, 1);
      pulse_rd();
      pulse_clr();
      check("R7 clr perr", par_err_o, 0);
    end
  endtask

  task automatic t_none();
    par_mode_i = 3'd4;
    send_frame(8'h3C, 0, 1);
    check("R4 data", data_o, 8'h3C);
    check("R4 no perr", par_err_o, 0);
    check("R4 no ferr", frm_err_o, 0);
    pulse_rd();
    par_mode_i = 3'd7;
    send_frame(8'h81, 0, 1);
    check("R4 mode7 data", data_o, 8'h81);
    check("R4 mode7 no perr", par_err_o, 0);
    pulse_rd();
  endtask

  task automatic t_frame();
    par_mode_i = 3'd1;
    send_frame(8'h77, 0, 0);
    check("R5 ferr set", frm_err_o, 1);
    check("R5 data", data_o, 8'h77);
    pulse_rd();
    send_frame(8'h12, 0, 1);
    check("R7 ferr held", frm_err_o, 1);
    check("R9 no glitch char after low stop", data_o, 8'h12);
    pulse_rd();
    check("R7 ferr held after rd", frm_err_o, 1);
    pulse_clr();
    check("R7 ferr cleared", frm_err_o, 0);
  endtask

  task automatic t_overrun();
    par_mode_i = 3'd0;
    send_frame(8'h11, 0, 1);
    check("R6 no ovr yet", ovr_o, 0);
    send_frame(8'h22, 0, 1);
    check("R6 ovr set", ovr_o, 1);
    check("R6 newest data", data_o, 8'h22);
    pulse_rd();
    check("R7 ovr held after rd", ovr_o, 1);
    pulse_clr();
    check("R7 ovr cleared", ovr_o, 0);
  endtask

  task automatic t_false_start();
    rxd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (40) @(negedge clk_i);
    check("R9 no ready", ready_o, 0);
    check("R9 data kept", data_o, 8'h22);
  endtask

  task automatic t_priority();
    par_mode_i = 3'd0;
    rst_sta_i = 1'b1;
    fork
      send_frame(8'h9E, 1, 1);
      begin
        while (!ready_o) @(negedge clk_i);
        check("R8 perr wins over clear", par_err_o, 1);
        rst_sta_i = 1'b0;
      end
    join
    check("R8 perr remains", par_err_o, 1);
    pulse_rd();
    pulse_clr();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    t_reset();
    t_basic();
    t_modes();
    t_none();
    t_frame();
    t_overrun();
    t_false_start();
    t_priority();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule